// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple 32-bit register bus. Its data register shows up at 256 word addresses, and the low eight bits of the word address act as a per-pin mask. A driver that owns only some pins can set or clear them, or sample them, with one access. It never needs a read-modify-write, and it cannot disturb pins that belong to another driver.

A separate direction word chooses, pin by pin, whether the stored output value is driven out (output enable high) or whether the pin is read through a two-flop synchronizer. The bus has no handshake. An access takes the cycle in which its strobe is high, and read data is registered at that clock edge.

Each bus cycle is sorted into one of seven access classes. The class then steers a `unique case` in the register process and in the read process. The classes are:
- ACC_IDLE: no strobe.
- ACC_DATA_WR and ACC_DATA_RD: byte addresses 0x000 to 0x3FC.
- ACC_DIR_WR and ACC_DIR_RD: byte address 0x400.
- ACC_MISS_WR and ACC_MISS_RD: any other address.

When both strobes are high, the write wins. The only sequential states are the data word, the direction word, the two synchronizer stages and the read-data register. All of them go to zero on reset.

Top module: `gpio_masked_port`

## Requirements
- R1: Every word address 0x000 to 0x0FF (byte 0x000 to 0x3FC) reaches the same eight data bits, so a value written through one alias reads back through any other alias whose mask covers it.
- R2: On a data write, pin i changes only when mask bit i (word address bit i) is 1. Every other stored bit keeps its value.
- R3: On a data write, a stored bit changes only if its direction bit is 1 (output). Bits of input pins keep their value.
- R4: On a data read, every bit whose mask bit is 0 reads 0.
- R5: On a data read, an unmasked bit returns the stored value when the pin is an output. When the pin is an input, it returns the pin level that has been stable for at least two clocks before the read edge.
- R6: Read-data bits [31:8] are always 0, and write-data bits [31:8] have no effect.
- R7: After reset, the data word, the direction word, pin_oe, pin_out and bus_rdata are all 0, so every pin starts as an input.
- R8: The direction word sits at word address 0x100 (byte 0x400). A 1 in bit i makes pin i an output, and the word reads back unmasked.
- R9: pin_oe equals the direction word and pin_out equals the stored data word at all times.
- R10: Writes to word addresses 0x101 and above change nothing, and reads from them return 0.
- R11: bus_rdata is loaded at the clock edge that samples bus_rd and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word_addr | input | 10 | Word address, equal to byte address bits [11:2] |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The properties assume that bus_wr and bus_rd are never high in the same cycle, and that both strobes are low during reset. They also assume that the strobes are single-cycle pulses driven between clock edges. The stimulus meets these conditions by driving every access from one task that raises exactly one strobe for a single cycle. Input pins change only between accesses, and are then held for two idle clocks before any read, so that the synchronized value is settled and the expected read value is exact.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Access classes; one per bus cycle, write wins over read
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_DATA_WR,
        ACC_DATA_RD,
        ACC_DIR_WR,
        ACC_DIR_RD,
        ACC_MISS_WR,
        ACC_MISS_RD
    } acc_kind_e;

endpackage

// File: rtl/gpio_acc_decode.sv
module gpio_acc_decode
    import gpio_mask_pkg::*;
#(
    parameter int PINS = 8,
    parameter int WAW  = PINS + 2
) (
    input  logic [WAW-1:0] word_addr,
    input  logic           wr,
    input  logic           rd,
    output acc_kind_e      kind
);
    // Data window: all words with upper bits zero; direction word just above it
    localparam logic [WAW-1:0] DIR_WORD = WAW'(1) << PINS;

    logic in_data;
    logic in_dir;

    assign in_data = (word_addr[WAW-1:PINS] == '0);
    assign in_dir  = (word_addr == DIR_WORD);

    always_comb begin
        kind = ACC_IDLE;
        if (wr) begin
            if (in_data)     kind = ACC_DATA_WR;
            else if (in_dir) kind = ACC_DIR_WR;
            else             kind = ACC_MISS_WR;
        end else if (rd) begin
            if (in_data)     kind = ACC_DATA_RD;
            else if (in_dir) kind = ACC_DIR_RD;
            else             kind = ACC_MISS_RD;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PINS   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_in[i]};
        end
        assign sync_out[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_mask_pkg::*;
#(
    parameter int PINS = 8,
    parameter int DW   = 32,
    parameter int WAW  = PINS + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WAW-1:0]  bus_word_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe
);
    acc_kind_e       kind;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] wr_bits;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] rd_view;
    logic [DW-1:0]   rdata_q;
    logic            unused_wdata_hi;

    assign mask            = bus_word_addr[PINS-1:0];
    assign wr_bits         = mask & dir_q;
    assign unused_wdata_hi = ^bus_wdata[DW-1:PINS];

    gpio_acc_decode #(.PINS(PINS), .WAW(WAW)) u_dec (
        .word_addr (bus_word_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .kind      (kind)
    );

    gpio_in_sync #(.PINS(PINS), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // Register state: data and direction words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            unique case (kind)
                ACC_DATA_WR: data_q <= (data_q & ~wr_bits) | (bus_wdata[PINS-1:0] & wr_bits);
                ACC_DIR_WR:  dir_q  <= bus_wdata[PINS-1:0];
                ACC_IDLE, ACC_DATA_RD, ACC_DIR_RD, ACC_MISS_WR, ACC_MISS_RD: ;
                default: ;
            endcase
        end
    end

    // Per-pin read source: stored value for outputs, synchronized level for inputs
    assign rd_view = (dir_q & data_q) | (~dir_q & pin_sync);

    // Read response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (kind)
                ACC_DATA_RD: rdata_q <= DW'(rd_view & mask);
                ACC_DIR_RD:  rdata_q <= DW'(dir_q);
                ACC_MISS_RD: rdata_q <= '0;
                ACC_IDLE, ACC_DATA_WR, ACC_DIR_WR, ACC_MISS_WR: ;
                default: ;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = data_q;
    assign pin_oe    = dir_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
    parameter int PINS = 8,
    parameter int DW   = 32,
    parameter int WAW  = PINS + 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [WAW-1:0]  bus_word_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [PINS-1:0] pin_out,
    input logic [PINS-1:0] pin_oe
);
    localparam logic [WAW-1:0] DIR_WORD = WAW'(1) << PINS;

    logic data_hit;
    logic dir_hit;
    logic miss_hit;
    assign data_hit = (bus_word_addr[WAW-1:PINS] == '0);
    assign dir_hit  = (bus_word_addr == DIR_WORD);
    assign miss_hit = !data_hit && !dir_hit;

    AST_WRITE_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && data_hit) |=> (((pin_out ^ $past(pin_out)) & ~$past(bus_word_addr[PINS-1:0])) == '0)); // R2
    AST_INPUT_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && data_hit) |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0)); // R3
    AST_READ_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && data_hit) |=> ((bus_rdata[PINS-1:0] & ~$past(bus_word_addr[PINS-1:0])) == '0)); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:PINS] == '0); // R6
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dir_hit) |=> (pin_oe == $past(bus_wdata[PINS-1:0]))); // R9
    AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && miss_hit) |=> ($stable(pin_out) && $stable(pin_oe))); // R10
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && miss_hit) |=> (bus_rdata == '0)); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11

endmodule

bind gpio_masked_port gpio_masked_port_chk #(.PINS(PINS), .DW(DW), .WAW(WAW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_word_addr (bus_word_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe)
);

// File: tb/tb_gpio_masked_port.sv
`timescale 1ns/1ps
module tb_gpio_masked_port;
    localparam int PINS = 8;
    localparam int DW   = 32;
    localparam int WAW  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [WAW-1:0]  bus_word_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out;
    logic [PINS-1:0] pin_oe;

    int vectors = 0;
    int fails   = 0;
    logic [7:0] m_data = '0;
    logic [7:0] m_dir  = '0;

    always #2 clk = ~clk;

    gpio_masked_port #(.PINS(PINS), .DW(DW), .WAW(WAW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_word_addr(bus_word_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [9:0] wa);
        if (wa < 10'h100)       return {24'h0, ((m_dir & m_data) | (~m_dir & pin_in)) & wa[7:0]};
        else if (wa == 10'h100) return {24'h0, m_dir};
        else                    return 32'h0;
    endfunction

    task automatic bus_write(input logic [9:0] wa, input logic [31:0] d);
        @(negedge clk);
        bus_word_addr = wa; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (wa < 10'h100) m_data = (m_data & ~(wa[7:0] & m_dir)) | (d[7:0] & wa[7:0] & m_dir);
        else if (wa == 10'h100) m_dir = d[7:0];
    endtask

    task automatic bus_read(input logic [9:0] wa, output logic [31:0] q);
        @(negedge clk);
        bus_word_addr = wa; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_check(input string tag, input logic [9:0] wa);
        logic [31:0] e, q;
        e = exp_read(wa);
        bus_read(wa, q);
        check(tag, q, e);
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] q, held;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 rdata", bus_rdata, 32'h0);
        check("R7 pin_oe", {24'h0, pin_oe}, 32'h0);
        check("R7 pin_out", {24'h0, pin_out}, 32'h0);
        read_check("R7 dir", 10'h100);
        // R8 direction register
        bus_write(10'h100, 32'hFFFF_FF0F);
        read_check("R8 dir readback", 10'h100);
        check("R9 oe", {24'h0, pin_oe}, 32'h0F);
        // R3 writes only touch outputs
        bus_write(10'h0FF, 32'h0000_00FF);
        check("R3 out", {24'h0, pin_out}, 32'h0F);
        // R2 mask limits write
        bus_write(10'h001, 32'h0);
        check("R2 out", {24'h0, pin_out}, 32'h0E);
        // R5 inputs via synchronizer, R4 masked read
        set_pins(8'hA5);
        read_check("R5 full", 10'h0FF);
        read_check("R4 partial", 10'h03C);
        // R6 upper write bits ignored and read zero
        bus_write(10'h100, 32'hFFFF_FFFF);
        bus_write(10'h0FF, 32'hABCD_EF3C);
        read_check("R6 upper", 10'h0FF);
        check("R9 out", {24'h0, pin_out}, {24'h0, m_data});
        // R1 aliasing
        bus_write(10'h080, 32'h80);
        read_check("R1 alias a", 10'h0C0);
        read_check("R1 alias b", 10'h0FF);
        // R10 unmapped
        bus_write(10'h101, 32'h0);
        bus_write(10'h3FF, 32'h0);
        check("R10 dir kept", {24'h0, pin_oe}, 32'hFF);
        check("R10 data kept", {24'h0, pin_out}, {24'h0, m_data});
        read_check("R10 miss read", 10'h2A0);
        // R11 rdata holds
        read_check("R11 load", 10'h0FF);
        held = bus_rdata;
        repeat (3) @(negedge clk);
        bus_write(10'h0FF, 32'h0);
        check("R11 hold", bus_rdata, held);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [9:0] wa;
            op = int'($urandom_range(0, 5));
            wa = 10'($urandom_range(0, 255));
            unique case (op)
                0: begin
                    bus_write(wa, $urandom());
                    check("R2 R3 rand out", {24'h0, pin_out}, {24'h0, m_data});
                end
                1: begin
                    bus_write(10'h100, $urandom());
                    check("R9 rand oe", {24'h0, pin_oe}, {24'h0, m_dir});
                end
                2: read_check("R4 R5 rand read", wa);
                3: read_check("R8 rand dir", 10'h100);
                4: begin
                    wa = 10'($urandom_range(257, 1023));
                    bus_write(wa, $urandom());
                    read_check("R10 rand miss", wa);
                end
                default: set_pins(8'($urandom()));
            endcase
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule